// File: doc/BRIEF.md
# IP-to-MAC Resolution Cache

This block keeps a small table of learned IPv4-to-MAC pairs for a UDP transmit path. The transmit logic presents a destination IP whenever that address changes. If a valid entry holds the address, the stored MAC comes back on the following clock. If no entry holds it, the block raises a request to an external address-resolution engine and waits for its answer. When the answer arrives, the new pair is written into the table and returned to the requester. If no answer arrives within a programmable number of cycles, the block reports failure and writes nothing.

Slots are numbered from 1 to `NUM_ENTRIES`. Slot 0 is reserved and never holds data. New pairs go into the slots in ascending order. Once the last slot has been written, the next new pair overwrites slot 1 and filling continues around the ring.

A second, independent port reads a slot directly by its number. A stream's routing field drives this port. A non-zero routing value selects the stored pair in that slot. A routing value that points at an empty slot, or past the end of the table, tells the stream logic to discard the packet. A routing value of zero means the normal IP-based lookup applies.

Top module: `ip_mac_cache`

## Requirements
- R1: After reset every slot is empty, `lk_ready`=1, `rsp_valid`=0 and `arp_req`=0. Any non-zero `idx_sel` then gives `idx_drop`=1.
- R2: A request is accepted when `lk_req`=1 and `lk_ready`=1. When the requested IP is held in a valid slot, the cycle after acceptance shows `rsp_valid`=1, `rsp_ok`=1 and that slot's MAC, and `arp_req` stays 0.
- R3: An accepted request whose IP is not held drives `arp_req`=1 with `arp_ip` equal to the requested IP, starting the cycle after acceptance. It stays that way, with `lk_ready`=0, until the reply or the timeout.
- R4: While `arp_req`=1, a cycle with `arp_rsp_valid`=1 writes the pair into the current fill slot. The next cycle shows `rsp_valid`=1, `rsp_ok`=1 and `rsp_mac` equal to the replied MAC. Later requests for that IP hit.
- R5: Learned pairs fill slot 1, then slot 2, and so on in order of arrival.
- R6: After slot `NUM_ENTRIES` is written, the next learned pair overwrites slot 1. The IP that was evicted misses afterwards.
- R7: The wait lasts at most `tmo_limit`+1 cycles. If no reply has come in any of them, the following cycle shows `rsp_valid`=1, `rsp_ok`=0 and `rsp_mac`=0, with no slot written and the fill position unchanged. A reply in the last wait cycle is taken as a success.
- R8: For 1 ≤ `idx_sel` ≤ `NUM_ENTRIES` on a filled slot, `idx_use`=1 and `idx_ip`/`idx_mac` show that slot's pair in the same cycle, with no clock delay.
- R9: For a non-zero `idx_sel` that names an empty slot or a value above `NUM_ENTRIES`, `idx_drop`=1, `idx_use`=0, and `idx_ip` and `idx_mac` are 0.
- R10: `idx_sel`=0 gives `idx_use`=0 and `idx_drop`=0. No slot numbered 0 is ever written.
- R11: `arp_rsp_valid` has no effect while `arp_req`=0: no response is produced and no slot is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_ip | input | 32 | IP address to resolve |
| lk_ready | output | 1 | Block can accept a lookup |
| rsp_valid | output | 1 | One-cycle lookup result strobe |
| rsp_ok | output | 1 | Result carries a MAC (0 = resolution failed) |
| rsp_mac | output | 48 | Resolved MAC address |
| idx_sel | input | clog2(NUM_ENTRIES+1) | Slot number taken from the stream routing field |
| idx_use | output | 1 | Selected slot holds a valid pair |
| idx_drop | output | 1 | Non-zero selection with no valid pair; discard the packet |
| idx_ip | output | 32 | IP stored in the selected slot |
| idx_mac | output | 48 | MAC stored in the selected slot |
| arp_req | output | 1 | Resolution request, held while waiting |
| arp_ip | output | 32 | IP to resolve |
| arp_rsp_valid | input | 1 | Resolution reply strobe |
| arp_rsp_mac | input | 48 | MAC from the resolution reply |
| tmo_limit | input | TMO_W | Wait limit; the wait spans tmo_limit+1 cycles |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a resolution reply and the timeout. The bench delays the reply so that it lands exactly in the last wait cycle, and the reply must win. The second pair is a table write and a direct index read of the slot being written. The bench points `idx_sel` at the current fill slot during the reply cycle. In that cycle the index port must still show the old contents, and the new pair must appear one cycle later. A behavioural model in the bench predicts every output on every clock, so both outcomes are judged against its expected values.

// File: rtl/ipc_pkg.sv
`timescale 1ns/1ps
package ipc_pkg;
    localparam int IP_W  = 32;
    localparam int MAC_W = 48;

    typedef logic [IP_W-1:0]  ip_t;
    typedef logic [MAC_W-1:0] mac_t;

    // one cache line
    typedef struct packed {
        logic valid;
        ip_t  ip;
        mac_t mac;
    } entry_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_state_t;

    // width of a slot number able to hold 0..n
    function automatic int slot_bits(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/ipc_store.sv
`timescale 1ns/1ps
module ipc_store
    import ipc_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  ip_t           wr_ip,
    input  mac_t          wr_mac,
    input  ip_t           q_ip,
    output logic          q_hit,
    output mac_t          q_mac,
    input  logic [SW-1:0] x_sel,
    output logic          x_use,
    output logic          x_drop,
    output ip_t           x_ip,
    output mac_t          x_mac
);
    entry_t         tbl [N];
    logic   [N-1:0] match;
    entry_t         sel_e;

    // slot k (1..N) lives in tbl[k-1]
    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g] <= '0;
            end else if (wr_en && wr_slot == SW'(g + 1)) begin
                tbl[g] <= '{valid: 1'b1, ip: wr_ip, mac: wr_mac};
            end
        end
        assign match[g] = tbl[g].valid && (tbl[g].ip == q_ip);
    end

    // IPs are unique in the table, so an OR of the matching lines is exact
    always_comb begin
        q_mac = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) q_mac = q_mac | tbl[i].mac;
        end
    end
    assign q_hit = |match;

    // direct read by slot number
    always_comb begin
        sel_e = '0;
        for (int i = 0; i < N; i++) begin
            if (x_sel == SW'(i + 1)) sel_e = tbl[i];
        end
    end

    assign x_use  = sel_e.valid;
    assign x_drop = (x_sel != '0) && !sel_e.valid;
    assign x_ip   = sel_e.valid ? sel_e.ip  : '0;
    assign x_mac  = sel_e.valid ? sel_e.mac : '0;
endmodule

// File: rtl/ipc_ctrl.sv
`timescale 1ns/1ps
module ipc_ctrl
    import ipc_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 3,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_req,
    input  ip_t           lk_ip,
    output logic          lk_ready,
    input  logic          hit,
    input  mac_t          hit_mac,
    input  logic          arp_rsp_valid,
    input  mac_t          arp_rsp_mac,
    input  logic [TW-1:0] tmo_limit,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output mac_t          rsp_mac,
    output logic          arp_req,
    output ip_t           arp_ip,
    output logic          wr_en,
    output logic [SW-1:0] wr_slot,
    output ip_t           wr_ip,
    output mac_t          wr_mac
);
    ctl_state_t    state;
    ip_t           pend_ip;
    logic [TW-1:0] wait_cnt;
    logic [SW-1:0] fill_ptr;
    logic [SW-1:0] fill_nxt;

    // ring of slots 1..N, slot 0 skipped
    assign fill_nxt = (fill_ptr == SW'(N)) ? SW'(1) : fill_ptr + SW'(1);

    assign lk_ready = (state == ST_IDLE);
    assign arp_req  = (state == ST_WAIT);
    assign arp_ip   = pend_ip;
    assign wr_en    = arp_req && arp_rsp_valid;
    assign wr_slot  = fill_ptr;
    assign wr_ip    = pend_ip;
    assign wr_mac   = arp_rsp_mac;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend_ip   <= '0;
            wait_cnt  <= '0;
            fill_ptr  <= SW'(1);
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_mac   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_mac   <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (lk_req) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_ok    <= 1'b1;
                            rsp_mac   <= hit_mac;
                        end else begin
                            state    <= ST_WAIT;
                            pend_ip  <= lk_ip;
                            wait_cnt <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (arp_rsp_valid) begin
                        // reply wins over a timeout in the same cycle
                        state     <= ST_IDLE;
                        fill_ptr  <= fill_nxt;
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b1;
                        rsp_mac   <= arp_rsp_mac;
                    end else if (wait_cnt == tmo_limit) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + TW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ip_mac_cache.sv
`timescale 1ns/1ps
module ip_mac_cache
    import ipc_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int TMO_W       = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               lk_req,
    input  logic [IP_W-1:0]                    lk_ip,
    output logic                               lk_ready,
    output logic                               rsp_valid,
    output logic                               rsp_ok,
    output logic [MAC_W-1:0]                   rsp_mac,
    input  logic [$clog2(NUM_ENTRIES+1)-1:0]   idx_sel,
    output logic                               idx_use,
    output logic                               idx_drop,
    output logic [IP_W-1:0]                    idx_ip,
    output logic [MAC_W-1:0]                   idx_mac,
    output logic                               arp_req,
    output logic [IP_W-1:0]                    arp_ip,
    input  logic                               arp_rsp_valid,
    input  logic [MAC_W-1:0]                   arp_rsp_mac,
    input  logic [TMO_W-1:0]                   tmo_limit
);
    localparam int SLOT_W = slot_bits(NUM_ENTRIES);

    logic              hit;
    mac_t              hit_mac;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    ip_t               wr_ip;
    mac_t              wr_mac;

    ipc_store #(.N(NUM_ENTRIES), .SW(SLOT_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_ip   (wr_ip),
        .wr_mac  (wr_mac),
        .q_ip    (lk_ip),
        .q_hit   (hit),
        .q_mac   (hit_mac),
        .x_sel   (idx_sel),
        .x_use   (idx_use),
        .x_drop  (idx_drop),
        .x_ip    (idx_ip),
        .x_mac   (idx_mac)
    );

    ipc_ctrl #(.N(NUM_ENTRIES), .SW(SLOT_W), .TW(TMO_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .lk_req        (lk_req),
        .lk_ip         (lk_ip),
        .lk_ready      (lk_ready),
        .hit           (hit),
        .hit_mac       (hit_mac),
        .arp_rsp_valid (arp_rsp_valid),
        .arp_rsp_mac   (arp_rsp_mac),
        .tmo_limit     (tmo_limit),
        .rsp_valid     (rsp_valid),
        .rsp_ok        (rsp_ok),
        .rsp_mac       (rsp_mac),
        .arp_req       (arp_req),
        .arp_ip        (arp_ip),
        .wr_en         (wr_en),
        .wr_slot       (wr_slot),
        .wr_ip         (wr_ip),
        .wr_mac        (wr_mac)
    );
endmodule

// File: rtl/ipc_chk.sv
`timescale 1ns/1ps
module ipc_chk
    import ipc_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int TMO_W       = 16
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             lk_req,
    input logic                             lk_ready,
    input logic                             rsp_valid,
    input logic                             rsp_ok,
    input logic [MAC_W-1:0]                 rsp_mac,
    input logic [$clog2(NUM_ENTRIES+1)-1:0] idx_sel,
    input logic                             idx_use,
    input logic                             idx_drop,
    input logic                             arp_req,
    input logic [IP_W-1:0]                  arp_ip,
    input logic                             arp_rsp_valid,
    input logic [MAC_W-1:0]                 arp_rsp_mac
);
    // R2
    req_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_ready) |=> (rsp_valid || arp_req));

    // R3
    wait_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        arp_req |-> !lk_ready);

    // R3
    arp_ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (arp_req && $past(arp_req)) |-> $stable(arp_ip));

    // R4
    reply_result_chk: assert property (@(posedge clk) disable iff (rst)
        (arp_req && arp_rsp_valid) |=>
            (rsp_valid && rsp_ok && rsp_mac == $past(arp_rsp_mac)));

    // R7
    fail_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> ($past(arp_req) && rsp_mac == '0));

    // R10
    idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_sel == '0) |-> (!idx_use && !idx_drop));

    // R9
    idx_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({idx_use, idx_drop}));

    // R11
    stray_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (arp_rsp_valid && !arp_req && !(lk_req && lk_ready)) |=> !rsp_valid);
endmodule

bind ip_mac_cache ipc_chk #(.NUM_ENTRIES(NUM_ENTRIES), .TMO_W(TMO_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_req        (lk_req),
    .lk_ready      (lk_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ok        (rsp_ok),
    .rsp_mac       (rsp_mac),
    .idx_sel       (idx_sel),
    .idx_use       (idx_use),
    .idx_drop      (idx_drop),
    .arp_req       (arp_req),
    .arp_ip        (arp_ip),
    .arp_rsp_valid (arp_rsp_valid),
    .arp_rsp_mac   (arp_rsp_mac)
);

// File: tb/sim_ip_mac_cache.sv
`timescale 1ns/1ps
module sim_ip_mac_cache;
    localparam int N  = 4;
    localparam int SW = $clog2(N + 1);
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          lk_req;
    logic [31:0]   lk_ip;
    logic          lk_ready;
    logic          rsp_valid;
    logic          rsp_ok;
    logic [47:0]   rsp_mac;
    logic [SW-1:0] idx_sel;
    logic          idx_use;
    logic          idx_drop;
    logic [31:0]   idx_ip;
    logic [47:0]   idx_mac;
    logic          arp_req;
    logic [31:0]   arp_ip;
    logic          arp_rsp_valid;
    logic [47:0]   arp_rsp_mac;
    logic [TW-1:0] tmo_limit;

    always #2.5 clk = ~clk;

    ip_mac_cache #(.NUM_ENTRIES(N), .TMO_W(TW)) u0 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_ip(lk_ip), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_mac(rsp_mac),
        .idx_sel(idx_sel), .idx_use(idx_use), .idx_drop(idx_drop),
        .idx_ip(idx_ip), .idx_mac(idx_mac), .arp_req(arp_req), .arp_ip(arp_ip),
        .arp_rsp_valid(arp_rsp_valid), .arp_rsp_mac(arp_rsp_mac), .tmo_limit(tmo_limit)
    );

    // behavioural reference
    bit          m_val [N];
    logic [31:0] m_ip  [N];
    logic [47:0] m_mac [N];
    int          m_wp;
    bit          m_wait;
    logic [31:0] m_pend;
    int          m_cnt;
    bit          e_rv, e_ok;
    logic [47:0] e_mac;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string phase = "R1 reset";

    function automatic int find_ip(input logic [31:0] ip);
        for (int i = 0; i < N; i++) if (m_val[i] && m_ip[i] == ip) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_val[i] = 0; m_ip[i] = '0; m_mac[i] = '0; end
            m_wp = 1; m_wait = 0; m_pend = '0; m_cnt = 0;
            e_rv = 0; e_ok = 0; e_mac = '0;
        end else begin : step
            int f;
            e_rv = 0; e_ok = 0; e_mac = '0;
            if (!m_wait) begin
                if (lk_req) begin
                    f = find_ip(lk_ip);
                    if (f >= 0) begin e_rv = 1; e_ok = 1; e_mac = m_mac[f]; end
                    else begin m_wait = 1; m_pend = lk_ip; m_cnt = 0; end
                end
            end else if (arp_rsp_valid) begin
                m_val[m_wp-1] = 1; m_ip[m_wp-1] = m_pend; m_mac[m_wp-1] = arp_rsp_mac;
                m_wp = (m_wp == N) ? 1 : m_wp + 1;
                e_rv = 1; e_ok = 1; e_mac = arp_rsp_mac; m_wait = 0;
            end else if (m_cnt == int'(tmo_limit)) begin
                e_rv = 1; e_ok = 0; m_wait = 0;
            end else begin
                m_cnt++;
            end
        end
    end

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin : cmp
            int  s;
            bit  u;
            s = int'(idx_sel);
            u = (s != 0) && (s <= N) && m_val[(s == 0 || s > N) ? 0 : s-1];
            check("lk_ready", 64'(lk_ready), 64'(!m_wait));
            check("rsp_valid", 64'(rsp_valid), 64'(e_rv));
            check("rsp_ok", 64'(rsp_ok), 64'(e_ok));
            check("rsp_mac", 64'(rsp_mac), 64'(e_mac));
            check("arp_req", 64'(arp_req), 64'(m_wait));
            if (m_wait) check("arp_ip", 64'(arp_ip), 64'(m_pend));
            check("idx_use", 64'(idx_use), 64'(u));
            check("idx_drop", 64'(idx_drop), 64'((s != 0) && !u));
            check("idx_ip", 64'(idx_ip), u ? 64'(m_ip[s-1]) : 64'd0);
            check("idx_mac", 64'(idx_mac), u ? 64'(m_mac[s-1]) : 64'd0);
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic lookup(input logic [31:0] ip);
        lk_req = 1'b1; lk_ip = ip;
        @(negedge clk); #1;
        lk_req = 1'b0;
    endtask

    task automatic reply(input int dly, input logic [47:0] mac);
        idle(dly);
        arp_rsp_valid = 1'b1; arp_rsp_mac = mac;
        @(negedge clk); #1;
        arp_rsp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_req = 1'b0; lk_ip = '0; idx_sel = '0;
        arp_rsp_valid = 1'b0; arp_rsp_mac = '0; tmo_limit = TW'(5);
        idle(3);
        rst = 1'b0;
        phase = "R1 reset";
        for (int s = 0; s < 8; s++) begin idx_sel = SW'(s); idle(1); end
        idx_sel = '0;

        phase = "R3 R4 R5 first miss";
        lookup(32'h0A000001); reply(2, 48'h111111111111); idle(2);
        phase = "R2 hit";
        lookup(32'h0A000001); idle(2);

        phase = "R5 fill order";
        lookup(32'h0A000002); reply(1, 48'h222222222222); idle(1);
        lookup(32'h0A000003); reply(1, 48'h333333333333); idle(1);
        lookup(32'h0A000004); reply(0, 48'h444444444444); idle(1);
        lookup(32'h0A000003); idle(2);

        phase = "R8 R9 index port";
        for (int s = 0; s < 8; s++) begin idx_sel = SW'(s); idle(1); end

        phase = "R6 wrap";
        idx_sel = SW'(1);
        lookup(32'h0A000005); reply(0, 48'h555555555555); idle(2);
        lookup(32'h0A000001);
        phase = "R7 timeout";
        idle(9);
        lookup(32'h0A000002); idle(2);

        phase = "R7 reply on last wait cycle";
        idx_sel = SW'(2);
        lookup(32'h0A000006); reply(5, 48'h666666666666); idle(2);
        lookup(32'h0A000006); idle(2);

        phase = "R11 stray reply";
        reply(0, 48'hDEADBEEF0000); idle(2);
        lookup(32'h0A000007); idle(2);
        reply(3, 48'h777777777777); idle(2);

        phase = "R7 zero limit";
        tmo_limit = '0;
        lookup(32'h0A000008); idle(4);
        tmo_limit = TW'(5);

        phase = "R10 index zero";
        idx_sel = '0; idle(2);
        for (int s = 1; s <= N; s++) begin idx_sel = SW'(s); idle(1); end

        done = 1;
        summary();
        $finish;
    end
endmodule